// File: doc/BRIEF.md
# Bit-Serial Accumulator Shift and Rotate Unit

This unit shifts or rotates a 16-bit accumulator A, optionally joined with a companion register B, one bit position per clock. A carry flag C records the bits that leave the register, or, for arithmetic left shifts, whether the sign ever flipped. Bit 1 is the most significant bit of each register. In the RTL, A1 is `a[15]` and A16 is `a[0]`.

The unit waits in IDLE. A start pulse captures the operands, the mode and the step count n (0 to 63) and clears C. In the same edge it moves to RUN, or to FINISH directly when n is 0. RUN performs one single-bit step per clock and counts n down. It leaves for FINISH on the edge that performs the last step. FINISH raises done for one cycle and returns to IDLE on the next edge. The results stay on the output ports until the next accepted start. Surrounding control logic is expected to pass the results back into its register file.

Top module: `acc_shift_seq`

## Requirements
- R1: After reset, a_out, b_out and c_out are 0 and busy and done are low.
- R2: A start sampled in IDLE at edge k raises busy after that edge. Done is high only in the cycle between edges k+n and k+n+1. Busy then falls with done.
- R3: With n = 0 the operation finishes after edge k. a_out and b_out equal the captured operands and c_out is 0.
- R4: Mode 0 rotates A left: A1 wraps into A16 and is copied to C. Mode 1 rotates A right: A16 wraps into A1 and is copied to C.
- R5: Mode 2 shifts A left and fills with zeros. C ends at 1 if any step changed A1 and at 0 otherwise. A is 0 after 16 or more steps.
- R6: Mode 3 shifts A right, keeps A1 and copies it into the vacated position. A16 goes to C.
- R7: Mode 4 shifts A left with zero fill and A1 to C. Mode 5 shifts A right with zero fill and A16 to C.
- R8: Modes 8 and 9 rotate the 32-bit word A:B (A most significant) left and right. A1 and B16 feed each other through the wrap, and C takes the bit that leaves the end.
- R9: Modes 12 and 13 shift A:B left and right with zero fill. On left shifts B1 feeds A16 and A1 goes to C. On right shifts A16 feeds B1 and B16 goes to C. After 32 or more steps A:B is 0.
- R10: Modes 10 and 11 shift the 31 bits A:B2..B16 while B1 holds its value. In the left mode B2 feeds A16, zeros enter at B16, and C is set by any change of A1. In the right mode A16 feeds B2, A1 is copied into the vacated position, and B16 goes to C. After 30 or more right steps every bit except B1 equals the sign.
- R11: The single-register modes 0 to 5 leave B unchanged.
- R12: A start arriving while busy is ignored. The running operation's result and done timing are unaffected.
- R13: The unused mode codes 6, 7, 14 and 15 leave A and B unchanged and clear C, with the normal done timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| mode | input | 4 | Operation code, see requirements |
| count | input | 6 | Number of single-bit steps n |
| a_in | input | 16 | Operand for A |
| b_in | input | 16 | Operand for B |
| a_out | output | 16 | Current A |
| b_out | output | 16 | Current B |
| c_out | output | 1 | Current C |
| busy | output | 1 | Operation in progress (RUN or FINISH) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Arithmetic left shift of 0x4000 for 16 steps.** A non-sticky C would clear once the sign settled at zero, and a design with the wrong fill would leave A non-zero.
- **Long arithmetic shifts with B1 set.** A design that shifts all 32 bits would disturb B1. The 30-step right shift catches a design that fails to propagate the sign into B2.
- **n = 0.** Exposes an off-by-one in the counter, either as an extra step or a late done.
- **A second start mid-run.** Shows whether a design reloads its operands when it should ignore the pulse.
- **Unused mode codes.** Reveal whether a step leaks into A or B.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

    typedef enum logic [3:0] {
        MD_ROL  = 4'd0,
        MD_ROR  = 4'd1,
        MD_SAL  = 4'd2,
        MD_SAR  = 4'd3,
        MD_SHL  = 4'd4,
        MD_SHR  = 4'd5,
        MD_LROL = 4'd8,
        MD_LROR = 4'd9,
        MD_LSAL = 4'd10,
        MD_LSAR = 4'd11,
        MD_LSHL = 4'd12,
        MD_LSHR = 4'd13
    } shift_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } shift_state_e;

endpackage

// File: rtl/acc_shift_step.sv
module acc_shift_step
    import acc_shift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic         c_o
);
    localparam int LW = 2 * W;
    localparam int VW = 2 * W - 1;

    logic [LW-1:0] wide;
    logic [VW-1:0] nar;

    always_comb begin
        wide = {a_i, b_i};
        nar  = {a_i, b_i[W-2:0]};
        a_o  = a_i;
        b_o  = b_i;
        c_o  = c_i;
        unique case (mode)
            MD_ROL: begin
                c_o = a_i[W-1];
                a_o = {a_i[W-2:0], a_i[W-1]};
            end
            MD_ROR: begin
                c_o = a_i[0];
                a_o = {a_i[0], a_i[W-1:1]};
            end
            MD_SAL: begin
                c_o = c_i | (a_i[W-1] ^ a_i[W-2]);
                a_o = {a_i[W-2:0], 1'b0};
            end
            MD_SAR: begin
                c_o = a_i[0];
                a_o = {a_i[W-1], a_i[W-1:1]};
            end
            MD_SHL: begin
                c_o = a_i[W-1];
                a_o = {a_i[W-2:0], 1'b0};
            end
            MD_SHR: begin
                c_o = a_i[0];
                a_o = {1'b0, a_i[W-1:1]};
            end
            MD_LROL: begin
                c_o = wide[LW-1];
                {a_o, b_o} = {wide[LW-2:0], wide[LW-1]};
            end
            MD_LROR: begin
                c_o = wide[0];
                {a_o, b_o} = {wide[0], wide[LW-1:1]};
            end
            MD_LSHL: begin
                c_o = wide[LW-1];
                {a_o, b_o} = {wide[LW-2:0], 1'b0};
            end
            MD_LSHR: begin
                c_o = wide[0];
                {a_o, b_o} = {1'b0, wide[LW-1:1]};
            end
            MD_LSAL: begin
                c_o = c_i | (nar[VW-1] ^ nar[VW-2]);
                a_o = nar[VW-2:W-2];
                b_o = {b_i[W-1], nar[W-3:0], 1'b0};
            end
            MD_LSAR: begin
                c_o = nar[0];
                a_o = {nar[VW-1], nar[VW-1:W]};
                b_o = {b_i[W-1], nar[W-1:1]};
            end
            default: begin
                a_o = a_i;
                b_o = b_i;
                c_o = c_i;
            end
        endcase
    end

endmodule

// File: rtl/acc_shift_ctrl.sv
module acc_shift_ctrl
    import acc_shift_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done
);
    shift_state_e     state, state_nx;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= count;
        end else if (step) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = (count == '0) ? ST_FINISH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (remain == CNT_W'(1)) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

endmodule

// File: rtl/acc_shift_seq.sv
module acc_shift_seq
    import acc_shift_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    output logic [W-1:0]     a_out,
    output logic [W-1:0]     b_out,
    output logic             c_out,
    output logic             busy,
    output logic             done
);
    logic [W-1:0] a_q, b_q, a_nx, b_nx;
    logic         c_q, c_nx;
    logic [3:0]   mode_q;
    logic         load, step;

    acc_shift_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .count (count),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    acc_shift_step #(.W(W)) u_step (
        .mode (mode_q),
        .a_i  (a_q),
        .b_i  (b_q),
        .c_i  (c_q),
        .a_o  (a_nx),
        .b_o  (b_nx),
        .c_o  (c_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= 1'b0;
            mode_q <= '0;
        end else if (load) begin
            a_q    <= a_in;
            b_q    <= b_in;
            c_q    <= 1'b0;
            mode_q <= mode;
        end else if (step) begin
            a_q <= a_nx;
            b_q <= b_nx;
            c_q <= c_nx;
        end
    end

    assign a_out = a_q;
    assign b_out = b_q;
    assign c_out = c_q;

endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
    parameter int W     = 16,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic [W-1:0]     a_in,
    input logic [W-1:0]     b_in,
    input logic [W-1:0]     a_out,
    input logic [W-1:0]     b_out,
    input logic             c_out,
    input logic             busy,
    input logic             done,
    input logic [3:0]       mode_q
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == '0) |=>
            (done && a_out == $past(a_in) && b_out == $past(b_in) && !c_out));

    assert_single_keeps_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_q[3]) |=> (b_out == $past(b_out)));

    assert_b1_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == 4'd10 || mode_q == 4'd11)) |=> (b_out[W-1] == $past(b_out[W-1])));

    assert_sticky_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == 4'd2 && c_out) |=> c_out);

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> (mode_q == $past(mode_q)));

endmodule

bind acc_shift_seq acc_shift_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .count  (count),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .b_out  (b_out),
    .c_out  (c_out),
    .busy   (busy),
    .done   (done),
    .mode_q (mode_q)
);

// File: tb/sim_acc_shift_seq.sv
`timescale 1ns/1ps
module sim_acc_shift_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [5:0]  count = '0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, b_out;
    logic        c_out, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    acc_shift_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .c_out(c_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model written from the requirements.
    task automatic model(input logic [3:0] m, input int n,
                         input logic [15:0] a0, input logic [15:0] b0,
                         output logic [15:0] ea, output logic [15:0] eb, output logic ec);
        logic [15:0] a, b;
        logic [31:0] w;
        logic [30:0] v;
        logic c;
        a = a0; b = b0; c = 1'b0;
        for (int i = 0; i < n; i++) begin
            w = {a, b};
            v = {a, b[14:0]};
            case (m)
                4'd0: begin c = a[15]; a = {a[14:0], a[15]}; end
                4'd1: begin c = a[0]; a = {a[0], a[15:1]}; end
                4'd2: begin if (a[15] != a[14]) c = 1'b1; a = a << 1; end
                4'd3: begin c = a[0]; a = 16'($signed(a) >>> 1); end
                4'd4: begin c = a[15]; a = a << 1; end
                4'd5: begin c = a[0]; a = a >> 1; end
                4'd8: begin c = w[31]; w = {w[30:0], w[31]}; {a, b} = w; end
                4'd9: begin c = w[0]; w = {w[0], w[31:1]}; {a, b} = w; end
                4'd12: begin c = w[31]; w = w << 1; {a, b} = w; end
                4'd13: begin c = w[0]; w = w >> 1; {a, b} = w; end
                4'd10: begin
                    if (v[30] != v[29]) c = 1'b1;
                    v = v << 1;
                    a = v[30:15]; b = {b[15], v[14:0]};
                end
                4'd11: begin
                    c = v[0];
                    v = 31'($signed(v) >>> 1);
                    a = v[30:15]; b = {b[15], v[14:0]};
                end
                default: ;
            endcase
        end
        ea = a; eb = b; ec = c;
    endtask

    // Issues one operation and checks the result at the cycle done should appear.
    task automatic run_op(input logic [3:0] m, input int n, input logic [15:0] a,
                          input logic [15:0] b, input string tag);
        logic [15:0] ea, eb;
        logic ec;
        model(m, n, a, b, ea, eb, ec);
        @(negedge clk);
        mode = m; count = 6'(n); a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        if (n > 0) begin
            chk(done == 1'b0, "R2", "early done", 32'(done), 32'd0);
            repeat (n) @(negedge clk);
        end
        chk(done == 1'b1, "R2", "done timing", 32'(done), 32'd1);
        chk(a_out == ea, tag, "A result", 32'(a_out), 32'(ea));
        chk(b_out == eb, tag, "B result", 32'(b_out), 32'(eb));
        chk(c_out == ec, tag, "C result", 32'(c_out), 32'(ec));
        @(negedge clk);
        chk(!done && !busy, "R2", "done/busy after pulse", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk(a_out == 0 && b_out == 0 && c_out == 0, "R1", "regs after reset",
            {a_out, b_out} | 32'(c_out), 32'd0);
        chk(!busy && !done, "R1", "flags after reset", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_zero_count();
        run_op(4'd2, 0, 16'hC3A5, 16'h1234, "R3");
        run_op(4'd12, 0, 16'h8000, 16'hFFFF, "R3");
    endtask

    task automatic t_single_rotate();
        run_op(4'd0, 1, 16'h8001, 16'hAAAA, "R4");
        run_op(4'd0, 5, 16'h1234, 16'h5555, "R4");
        run_op(4'd1, 3, 16'h0005, 16'h0F0F, "R4");
        run_op(4'd1, 17, 16'hBEEF, 16'h0000, "R4");
    endtask

    task automatic t_arith_left();
        run_op(4'd2, 16, 16'h4000, 16'h1111, "R5");
        chk(a_out == 16'h0000 && c_out == 1'b1, "R5", "sticky C, zero A",
            {a_out, 15'd0, c_out}, 32'h0000_0001);
        run_op(4'd2, 3, 16'h1001, 16'h0000, "R5");
        run_op(4'd2, 2, 16'hC000, 16'h0000, "R5");
        run_op(4'd2, 40, 16'hFFFF, 16'h0000, "R5");
    endtask

    task automatic t_arith_right();
        run_op(4'd3, 4, 16'h8018, 16'h2222, "R6");
        run_op(4'd3, 20, 16'h9001, 16'h0000, "R6");
        run_op(4'd3, 2, 16'h7FFF, 16'h0000, "R6");
    endtask

    task automatic t_logical_single();
        run_op(4'd4, 1, 16'h8000, 16'h3333, "R7");
        run_op(4'd4, 7, 16'hF0F1, 16'h0000, "R7");
        run_op(4'd5, 1, 16'h0001, 16'h4444, "R7");
        run_op(4'd5, 9, 16'hA5A5, 16'h0000, "R7");
    endtask

    task automatic t_long_rotate();
        run_op(4'd8, 1, 16'h8000, 16'h0001, "R8");
        run_op(4'd8, 20, 16'h1234, 16'h89AB, "R8");
        run_op(4'd9, 1, 16'h0001, 16'h0001, "R8");
        run_op(4'd9, 33, 16'hCAFE, 16'h0F01, "R8");
    endtask

    task automatic t_long_logical();
        run_op(4'd12, 1, 16'h0000, 16'h8000, "R9");
        run_op(4'd12, 40, 16'hFFFF, 16'hFFFF, "R9");
        chk(a_out == 0 && b_out == 0, "R9", "32+ steps clear A:B",
            {a_out, b_out}, 32'd0);
        run_op(4'd13, 1, 16'h0001, 16'h0000, "R9");
        run_op(4'd13, 17, 16'h8421, 16'h0003, "R9");
    endtask

    task automatic t_long_arith();
        run_op(4'd10, 1, 16'h0000, 16'hC000, "R10");
        run_op(4'd10, 5, 16'h0800, 16'hFFFF, "R10");
        run_op(4'd11, 30, 16'h8000, 16'h0001, "R10");
        chk(a_out == 16'hFFFF && b_out == 16'h7FFF, "R10", "30 right steps to sign",
            {a_out, b_out}, 32'hFFFF_7FFF);
        run_op(4'd11, 3, 16'h0007, 16'h8005, "R10");
    endtask

    task automatic t_b_untouched();
        run_op(4'd4, 12, 16'h0F0F, 16'hDEAD, "R11");
        chk(b_out == 16'hDEAD, "R11", "B kept by single mode", 32'(b_out), 32'h0000_DEAD);
    endtask

    task automatic t_busy_start();
        logic [15:0] ea, eb;
        logic ec;
        model(4'd0, 10, 16'h8001, 16'h0000, ea, eb, ec);
        @(negedge clk);
        mode = 4'd0; count = 6'd10; a_in = 16'h8001; b_in = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mode = 4'd5; count = 6'd1; a_in = 16'hFFFF; b_in = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R12", "no early done", 32'(done), 32'd0);
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R12", "done timing kept", 32'(done), 32'd1);
        chk(a_out == ea && b_out == eb && c_out == ec, "R12", "result unaffected",
            {a_out, b_out}, {ea, eb});
        @(negedge clk);
    endtask

    task automatic t_unused_modes();
        run_op(4'd6, 3, 16'h1234, 16'h5678, "R13");
        run_op(4'd15, 5, 16'hFFFF, 16'h0001, "R13");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_count();
        t_single_rotate();
        t_arith_left();
        t_arith_right();
        t_logical_single();
        t_long_rotate();
        t_long_logical();
        t_long_arith();
        t_b_untouched();
        t_busy_start();
        t_unused_modes();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule